// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block sits between a multi-channel HDLC deframer and the receive FIFO. For each of four time-shared receive channels it decides whether the current frame is kept or dropped. It looks at one octet: the first one that follows the opening flag. The 6-bit SAPI field of that octet is compared with three fixed reference values: group (63), signaling (0) and packet (16). Each reference can be switched into the comparison on its own. A mode bit chooses whether a match means "keep" or "drop". Filtering is switched on or off per channel, and a channel with filtering off keeps every frame.

The deframer supplies a channel index together with frame-start, octet-valid, closing-flag and abort strobes. The block reports the verdict one cycle after the deciding octet. It holds the verdict per channel for as long as the frame is open. When the frame ends, it reports a final keep/drop outcome that the FIFO uses to commit or discard what it has stored. A frame that closes before any octet, and a frame that is aborted, always end as dropped.

Top module: `hdlc_addr_filter`

## Requirements
- R1: After reset the control register is zero. `dec_vld`, `end_vld`, `ch_open` and `ch_dec` are 0, and every frame received before the first control write is kept.
- R2: Control layout: `ctl_din[3:0]` holds the filter enables of channels 0 to 3, bit 4 is the mode bit, bit 5 selects the group reference, bit 6 selects the signaling reference and bit 7 selects the packet reference. A `ctl_we` pulse loads the register. On a channel whose enable bit is 0, every frame is kept whatever the mode and selects are.
- R3: The SAPI is bits 7 down to 2 of the first octet. The three references are 63 (group), 0 (signaling) and 16 (packet).
- R4: With the mode bit at 1, a frame is kept exactly when its SAPI equals at least one selected reference.
- R5: With the mode bit at 0, a frame is dropped exactly when its SAPI equals at least one selected reference. Otherwise it is kept.
- R6: A match is the OR over the selected references only. With no reference selected nothing matches: frames are dropped when the mode bit is 1 and kept when it is 0.
- R7: Only the first octet after a frame start decides. Later octets of the same frame raise no `dec_vld` and leave `ch_keep` unchanged. A control write after the decision does not alter it.
- R8: The verdict is held in `ch_dec`/`ch_keep` until the closing flag or an abort on that channel. Channels keep independent state when their frames interleave.
- R9: A closing flag on an open channel gives `end_vld` one cycle later, with `end_chan` set to that channel and `end_keep` equal to the held verdict. An abort gives `end_keep` = 0. A frame that closes with no octet also gives `end_keep` = 0.
- R10: `dec_vld` pulses one cycle after the deciding octet, with `dec_keep` as the verdict and `dec_chan` as the channel.
- R11: Octets, closing flags and aborts on a channel with no open frame are ignored. They produce no `dec_vld` or `end_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register load strobe |
| ctl_din | input | 8 | Control value (layout in R2) |
| fr_start | input | 1 | Opening flag seen on `chan` |
| fr_end | input | 1 | Closing flag seen on `chan` |
| fr_abort | input | 1 | Abort seen on `chan` |
| byte_vld | input | 1 | Received octet valid on `chan` |
| byte_data | input | 8 | Received octet |
| chan | input | 2 | Channel index of the strobes |
| dec_vld | output | 1 | Verdict taken this cycle |
| dec_keep | output | 1 | Verdict: 1 keep, 0 drop |
| dec_chan | output | 2 | Channel of the verdict |
| end_vld | output | 1 | Frame ended |
| end_keep | output | 1 | Final outcome of the ended frame |
| end_chan | output | 2 | Channel of the ended frame |
| ch_open | output | 4 | Per-channel frame in progress |
| ch_dec | output | 4 | Per-channel verdict taken |
| ch_keep | output | 4 | Per-channel held verdict |

## Verification
The bench targets octets whose low six bits hold a reference value but whose SAPI field does not, such as 0x3F. A design that slices the wrong bits would keep such a frame in accept mode. It also runs with all references deselected in both modes, to catch a design that treats "no selection" as "match everything". It sends second octets and control writes into a frame that is already decided; a design that re-decides would change `ch_keep` or pulse `dec_vld` again. It sends aborts, frames that close with no octet, strays on closed channels and interleaved channels; these expose a design that commits dropped frames, reports phantom endings, or mixes up per-channel state.

// File: rtl/hdlc_afilt_pkg.sv
package hdlc_afilt_pkg;
  localparam int OCT_W   = 8;
  localparam int SAPI_W  = 6;
  localparam int NUM_REF = 3;
  // reference order: index 0 group, 1 signaling, 2 packet
  localparam logic [NUM_REF*SAPI_W-1:0] REF_VALS = {6'd16, 6'd0, 6'd63};

  function automatic logic [SAPI_W-1:0] sapi_of(input logic [OCT_W-1:0] oct);
    return oct[OCT_W-1 -: SAPI_W];
  endfunction

  function automatic logic keep_of(input logic filt_en, input logic accept_mode,
                                   input logic hit);
    if (!filt_en) return 1'b1;
    return accept_mode ? hit : !hit;
  endfunction
endpackage

// File: rtl/hdlc_sapi_cmp.sv
module hdlc_sapi_cmp
  import hdlc_afilt_pkg::*;
#(
  parameter int N_REF = NUM_REF,
  parameter logic [N_REF*SAPI_W-1:0] REFS = REF_VALS
) (
  input  logic [SAPI_W-1:0] sapi,
  input  logic [N_REF-1:0]  ref_sel,
  output logic [N_REF-1:0]  hit_vec,
  output logic              hit
);
  for (genvar r = 0; r < N_REF; r++) begin : g_ref
    assign hit_vec[r] = ref_sel[r] && (sapi == REFS[r*SAPI_W +: SAPI_W]);
  end
  assign hit = |hit_vec;
endmodule

// File: rtl/hdlc_chan_state.sv
module hdlc_chan_state (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic byte_ev,
  input  logic close,
  input  logic verdict,
  output logic open_o,
  output logic dec_o,
  output logic keep_o,
  output logic first_o
);
  logic open_q, dec_q, keep_q;

  // start wins over close; an octet coinciding with either is not a first octet
  assign first_o = byte_ev && open_q && !dec_q && !start && !close;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      dec_q  <= 1'b0;
      keep_q <= 1'b0;
    end else if (start) begin
      open_q <= 1'b1;
      dec_q  <= 1'b0;
      keep_q <= 1'b0;
    end else if (close) begin
      open_q <= 1'b0;
      dec_q  <= 1'b0;
      keep_q <= 1'b0;
    end else if (first_o) begin
      dec_q  <= 1'b1;
      keep_q <= verdict;
    end
  end

  assign open_o = open_q;
  assign dec_o  = dec_q;
  assign keep_o = keep_q;
endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter
  import hdlc_afilt_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int CTL_W = NUM_CH + 1 + NUM_REF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_we,
  input  logic [CTL_W-1:0]   ctl_din,
  input  logic               fr_start,
  input  logic               fr_end,
  input  logic               fr_abort,
  input  logic               byte_vld,
  input  logic [OCT_W-1:0]   byte_data,
  input  logic [CH_W-1:0]    chan,
  output logic               dec_vld,
  output logic               dec_keep,
  output logic [CH_W-1:0]    dec_chan,
  output logic               end_vld,
  output logic               end_keep,
  output logic [CH_W-1:0]    end_chan,
  output logic [NUM_CH-1:0]  ch_open,
  output logic [NUM_CH-1:0]  ch_dec,
  output logic [NUM_CH-1:0]  ch_keep
);
  logic [CTL_W-1:0]   ctl_q;
  logic [NUM_CH-1:0]  filt_en;
  logic               accept_mode;
  logic [NUM_REF-1:0] ref_sel;
  logic [NUM_REF-1:0] ref_hits;
  logic               sapi_hit;
  logic               verdict_cur;
  logic [NUM_CH-1:0]  chan_sel;
  logic [NUM_CH-1:0]  first_ev;
  logic               first_any;
  logic               close_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_we) ctl_q <= ctl_din;
  end

  assign filt_en     = ctl_q[NUM_CH-1:0];
  assign accept_mode = ctl_q[NUM_CH];
  assign ref_sel     = ctl_q[CTL_W-1 -: NUM_REF];

  hdlc_sapi_cmp #(.N_REF(NUM_REF), .REFS(REF_VALS)) u_cmp (
    .sapi    (sapi_of(byte_data)),
    .ref_sel (ref_sel),
    .hit_vec (ref_hits),
    .hit     (sapi_hit)
  );

  assign verdict_cur = keep_of(filt_en[chan], accept_mode, sapi_hit);

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) chan_sel[c] = (chan == CH_W'(c));
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    hdlc_chan_state u_st (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (fr_start && chan_sel[i]),
      .byte_ev (byte_vld && chan_sel[i]),
      .close   ((fr_end || fr_abort) && chan_sel[i]),
      .verdict (verdict_cur),
      .open_o  (ch_open[i]),
      .dec_o   (ch_dec[i]),
      .keep_o  (ch_keep[i]),
      .first_o (first_ev[i])
    );
  end

  assign first_any = |first_ev;
  assign close_ev  = (fr_end || fr_abort) && !fr_start && ch_open[chan];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_vld  <= 1'b0;
      dec_keep <= 1'b0;
      dec_chan <= '0;
      end_vld  <= 1'b0;
      end_keep <= 1'b0;
      end_chan <= '0;
    end else begin
      dec_vld  <= first_any;
      dec_keep <= first_any && verdict_cur;
      if (first_any) dec_chan <= chan;
      end_vld  <= close_ev;
      end_keep <= close_ev && fr_end && !fr_abort && ch_dec[chan] && ch_keep[chan];
      if (close_ev) end_chan <= chan;
    end
  end
endmodule

// File: rtl/hdlc_addr_filter_chk.sv
module hdlc_addr_filter_chk #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2,
  parameter int CTL_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fr_start,
  input logic              fr_end,
  input logic              fr_abort,
  input logic              byte_vld,
  input logic [CH_W-1:0]   chan,
  input logic [CTL_W-1:0]  ctl_q,
  input logic              first_any,
  input logic              close_ev,
  input logic              dec_vld,
  input logic              dec_keep,
  input logic [CH_W-1:0]   dec_chan,
  input logic              end_vld,
  input logic              end_keep,
  input logic [NUM_CH-1:0] ch_open,
  input logic [NUM_CH-1:0] ch_dec,
  input logic [NUM_CH-1:0] ch_keep
);
  logic quiet;
  assign quiet = !fr_start && !fr_end && !fr_abort;

  assert_unfiltered_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && byte_vld && ch_open[chan] && !ch_dec[chan] && !ctl_q[chan])
      |=> (dec_vld && dec_keep));

  assert_second_octet_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && ch_dec[chan]) |=> !dec_vld);

  assert_verdict_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !first_any) |=> $stable(ch_keep) && $stable(ch_dec));

  assert_abort_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_abort && !fr_start && ch_open[chan]) |=> (end_vld && !end_keep));

  assert_dec_timing_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld |-> ($past(byte_vld) && dec_chan == $past(chan)));

  assert_stray_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !ch_open[chan] && !close_ev) |=> !dec_vld);

  assert_dec_needs_open_R11: assert property (@(posedge clk) disable iff (!rst_n)
    end_vld |-> $past(close_ev));

  assert_dec_implies_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_dec & ~ch_open) == '0);
endmodule

bind hdlc_addr_filter hdlc_addr_filter_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W), .CTL_W(CTL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fr_start  (fr_start),
  .fr_end    (fr_end),
  .fr_abort  (fr_abort),
  .byte_vld  (byte_vld),
  .chan      (chan),
  .ctl_q     (ctl_q),
  .first_any (first_any),
  .close_ev  (close_ev),
  .dec_vld   (dec_vld),
  .dec_keep  (dec_keep),
  .dec_chan  (dec_chan),
  .end_vld   (end_vld),
  .end_keep  (end_keep),
  .ch_open   (ch_open),
  .ch_dec    (ch_dec),
  .ch_keep   (ch_keep)
);

// File: tb/sim_hdlc_addr_filter.sv
`timescale 1ns/1ps
module sim_hdlc_addr_filter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_din = '0;
  logic       fr_start = 1'b0, fr_end = 1'b0, fr_abort = 1'b0, byte_vld = 1'b0;
  logic [7:0] byte_data = '0;
  logic [1:0] chan = '0;
  logic       dec_vld, dec_keep, end_vld, end_keep;
  logic [1:0] dec_chan, end_chan;
  logic [3:0] ch_open, ch_dec, ch_keep;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hdlc_addr_filter u0 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_din(ctl_din),
    .fr_start(fr_start), .fr_end(fr_end), .fr_abort(fr_abort),
    .byte_vld(byte_vld), .byte_data(byte_data), .chan(chan),
    .dec_vld(dec_vld), .dec_keep(dec_keep), .dec_chan(dec_chan),
    .end_vld(end_vld), .end_keep(end_keep), .end_chan(end_chan),
    .ch_open(ch_open), .ch_dec(ch_dec), .ch_keep(ch_keep)
  );

  // vector: {ch[1:0], en, mode, sel[2:0] (b0 grp, b1 sig, b2 pkt), octet[7:0], exp_keep}
  localparam int NV = 14;
  localparam logic [15:0] VEC [NV] = '{
    {2'd0, 1'b0, 1'b1, 3'b000, 8'h44, 1'b1},  // R2 unfiltered
    {2'd1, 1'b1, 1'b1, 3'b001, 8'hFD, 1'b1},  // R4 group hit
    {2'd1, 1'b1, 1'b1, 3'b001, 8'h3F, 1'b0},  // R3 low bits 63, SAPI 15
    {2'd2, 1'b1, 1'b0, 3'b001, 8'hFD, 1'b0},  // R5 reject on hit
    {2'd2, 1'b1, 1'b0, 3'b001, 8'h44, 1'b1},  // R5 keep on miss
    {2'd3, 1'b1, 1'b1, 3'b010, 8'h02, 1'b1},  // R3 signaling 0
    {2'd3, 1'b1, 1'b1, 3'b100, 8'h02, 1'b0},  // R6 signaling not selected
    {2'd0, 1'b1, 1'b1, 3'b100, 8'h41, 1'b1},  // R3 packet 16
    {2'd0, 1'b1, 1'b1, 3'b000, 8'h41, 1'b0},  // R6 none selected, accept
    {2'd1, 1'b1, 1'b0, 3'b000, 8'hFD, 1'b1},  // R6 none selected, reject
    {2'd1, 1'b1, 1'b0, 3'b111, 8'h03, 1'b0},  // R5 all selected
    {2'd2, 1'b1, 1'b1, 3'b110, 8'hFC, 1'b0},  // R6 group not selected
    {2'd2, 1'b1, 1'b1, 3'b111, 8'h40, 1'b1},  // R4 OR of selects
    {2'd3, 1'b0, 1'b0, 3'b111, 8'hFF, 1'b1}   // R2 disabled beats reject
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_din = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic open_fr(input logic [1:0] ch);
    @(negedge clk); fr_start = 1'b1; chan = ch;
    @(negedge clk); fr_start = 1'b0;
  endtask

  // drives one octet; outputs are sampled at the following negedge
  task automatic send_oct(input logic [1:0] ch, input logic [7:0] b);
    byte_vld = 1'b1; chan = ch; byte_data = b;
    @(negedge clk); byte_vld = 1'b0;
  endtask

  task automatic close_fr(input logic [1:0] ch, input logic abort);
    fr_end = !abort; fr_abort = abort; chan = ch;
    @(negedge clk); fr_end = 1'b0; fr_abort = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 dec_vld", dec_vld, 0);
    chk("R1 end_vld", end_vld, 0);
    chk("R1 ch_open", ch_open, 0);
    chk("R1 ch_dec", ch_dec, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 no control write yet: reject-prone octet is kept
    open_fr(2'd2);
    send_oct(2'd2, 8'h02);
    chk("R1 dec_vld", dec_vld, 1);
    chk("R1 dec_keep", dec_keep, 1);
    close_fr(2'd2, 1'b0);
    chk("R1 end_keep", end_keep, 1);

    // table walk
    for (int k = 0; k < NV; k++) begin
      logic [1:0] vch;
      logic [7:0] cv;
      vch = VEC[k][15:14];
      cv  = {VEC[k][11:9], VEC[k][12], 4'(VEC[k][13]) << vch};
      wr_ctl(cv);
      open_fr(vch);
      send_oct(vch, VEC[k][8:1]);
      chk($sformatf("R10 vec%0d dec_vld", k), dec_vld, 1);
      chk($sformatf("R10 vec%0d dec_chan", k), dec_chan, vch);
      chk($sformatf("R3/R4/R5/R6 vec%0d dec_keep", k), dec_keep, VEC[k][0]);
      chk($sformatf("R8 vec%0d ch_keep", k), ch_keep[vch], VEC[k][0]);
      close_fr(vch, 1'b0);
      chk($sformatf("R9 vec%0d end_vld", k), end_vld, 1);
      chk($sformatf("R9 vec%0d end_chan", k), end_chan, vch);
      chk($sformatf("R9 vec%0d end_keep", k), end_keep, VEC[k][0]);
      chk($sformatf("R8 vec%0d closed", k), ch_open[vch], 0);
    end

    // R7 only first octet decides; later octets and ctl writes ignored
    wr_ctl(8'b001_1_0010);          // ch1 filtered, accept, group only
    open_fr(2'd1);
    send_oct(2'd1, 8'h44);          // miss -> drop
    chk("R7 first dec_keep", dec_keep, 0);
    send_oct(2'd1, 8'hFC);          // would hit
    chk("R7 second no dec_vld", dec_vld, 0);
    chk("R7 second ch_keep", ch_keep[1], 0);
    wr_ctl(8'b000_0_0000);
    chk("R7 ctl after decision", ch_keep[1], 0);
    close_fr(2'd1, 1'b0);
    chk("R7 end_keep", end_keep, 0);

    // R8 interleaved channels hold independent verdicts
    wr_ctl(8'b001_1_0011);          // ch0, ch1 filtered, accept group
    open_fr(2'd0);
    open_fr(2'd1);
    send_oct(2'd0, 8'hFF);          // ch0 keep
    send_oct(2'd1, 8'h10);          // ch1 drop
    chk("R8 ch_dec", ch_dec[1:0], 2'b11);
    chk("R8 ch_keep", ch_keep[1:0], 2'b01);
    close_fr(2'd1, 1'b0);
    chk("R8 ch1 end_keep", end_keep, 0);
    chk("R8 ch0 still open", ch_open[0], 1);
    chk("R8 ch0 still keep", ch_keep[0], 1);
    // R9 abort on kept frame drops it
    close_fr(2'd0, 1'b1);
    chk("R9 abort end_vld", end_vld, 1);
    chk("R9 abort end_keep", end_keep, 0);

    // R9 frame closing without any octet
    wr_ctl(8'h00);
    open_fr(2'd3);
    close_fr(2'd3, 1'b0);
    chk("R9 short end_vld", end_vld, 1);
    chk("R9 short end_keep", end_keep, 0);

    // R11 strays on closed channel
    send_oct(2'd3, 8'h40);
    chk("R11 stray octet", dec_vld, 0);
    chk("R11 stray ch_dec", ch_dec, 0);
    close_fr(2'd3, 1'b0);
    chk("R11 stray close", end_vld, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule